// File: doc/BRIEF.md
# Serial Flash Status and Protection Controller

This block keeps the status and control state of a serial NOR flash device and decides which write-type operations may proceed. An opcode decoder elsewhere in the chip hands it one command strobe per cycle: write enable, status write, enter or leave 32-bit addressing, program, erase, and enter or leave the one-time-programmable (OTP) area. It also sees the write-protect pin, the status data byte, the protection verdict for the addressed region, and the busy, done and fail lines of the program/erase sequencer.

From these it produces a status byte and an information byte for the read path, plus gating signals. These say whether the quad I/O fast read is allowed, whether the write-protect and hold pins keep their special functions, how wide addresses are, and when to start a program or erase. The protection bits, the quad enable and the OTP lock survive a warm reset. Only a separate factory-blank initialisation clears them. The write-enable latch, the addressing mode, the OTP mode and the fail flags are volatile.

A controller state machine with six states drives the timing. IDLE accepts commands. SRWR times the non-volatile status write and commits it in its last cycle. PGM_LAUNCH and ERS_LAUNCH last one cycle each and raise the start pulse. PGM_WAIT and ERS_WAIT hold until the sequencer reports done. Its transitions are these:
- IDLE goes to SRWR on an enabled status write.
- IDLE goes to PGM_LAUNCH or ERS_LAUNCH on an enabled program or erase that is not blocked.
- SRWR returns to IDLE when its counter expires.
- Each launch state moves to its wait state.
- Each wait state returns to IDLE when the sequencer reports done.

Top module: `sflash_status_ctrl`

## Requirements
- R1: Status bit 0 (busy) is 1 for exactly SRW_CYCLES cycles after an accepted status write. It is also 1 from the launch of a program or erase until the cycle after the sequencer reports done, and whenever the sequencer busy input is high.
- R2: Status bit 1 (write-enable latch) is set by the write-enable strobe. A status write, program or erase that arrives while it is 0 has no effect on any state and launches nothing.
- R3: The write-enable latch returns to 0 when an accepted status write commits, when a program or erase completes, and when a program or erase is rejected by protection.
- R4: A status write outside OTP mode loads data bits 5:2 into the block-protect field (status bits 5:2), bit 6 into quad enable (status bit 6) and bit 7 into the protect-lock bit. The commit happens at the end of the busy window. These bits keep their values through rst_n and are cleared only by nv_init_n.
- R5: quad_read_ok is 1 and wp_hold_en is 0 whenever quad enable is 1 or full_quad is 1. Otherwise quad_read_ok is 0 and wp_hold_en is 1. While wp_hold_en is 0, wp_n has no protective effect.
- R6: When the protect-lock bit is 1, wp_hold_en is 1 and wp_n is 0 as a status write is accepted, the protect-lock bit and block-protect field stay unchanged. Quad enable is still written.
- R7: In OTP mode (info bit 1) a status write ignores its data and sets the OTP lock. The lock is never cleared except by nv_init_n. Status bit 7 shows the OTP lock in OTP mode and the protect-lock bit outside it.
- R8: An enabled program or erase is blocked when, in OTP mode, the OTP lock is 1, or, outside OTP mode, tgt_protected is 1. In OTP mode tgt_protected is disregarded. A blocked operation raises no start pulse.
- R9: Info bit 0 (32-bit addressing) is set by the enter strobe and cleared by the leave strobe or by rst_n.
- R10: Info bit 2 (program fail) and bit 3 (erase fail) both clear when an enabled program, erase or status write is accepted. The matching flag then sets on a rejection or on seq_fail at completion. Both flags clear on rst_n.
- R11: Every command strobe is ignored while busy is 1.
- R12: prog_go and erase_go are single-cycle pulses in the cycle after acceptance, never high together, and only while the write-enable latch is still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| nv_init_n | input | 1 | Active-low factory-blank init; clears every bit |
| rst_n | input | 1 | Active-low power-cycle reset; clears volatile bits only |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_en4b | input | 1 | Enter 32-bit addressing strobe |
| cmd_ex4b | input | 1 | Leave 32-bit addressing strobe |
| cmd_prog | input | 1 | Program strobe |
| cmd_erase | input | 1 | Erase strobe |
| cmd_otp_enter | input | 1 | Enter OTP area strobe |
| cmd_otp_exit | input | 1 | Leave OTP area strobe |
| full_quad | input | 1 | Device is in full-quad protocol mode |
| wp_n | input | 1 | Write-protect pin level, active low |
| sr_wdata | input | 6 | Status write data bits 7:2 |
| tgt_protected | input | 1 | Addressed main-array region is block-protected |
| seq_busy | input | 1 | Sequencer busy |
| seq_done | input | 1 | Sequencer finished the current operation |
| seq_fail | input | 1 | Sequencer operation failed, valid with seq_done |
| status_reg | output | 8 | Status byte: busy, write-enable, block-protect, quad enable, lock |
| info_reg | output | 8 | Info byte: 32-bit mode, OTP mode, program fail, erase fail |
| wip | output | 1 | Busy, same as status bit 0 |
| quad_read_ok | output | 1 | Quad I/O fast read permitted |
| wp_hold_en | output | 1 | Write-protect and hold pins keep their functions |
| addr_32b | output | 1 | Addresses are 32 bits wide |
| prog_go | output | 1 | Start pulse to the program sequencer |
| erase_go | output | 1 | Start pulse to the erase sequencer |

## Verification
The bench targets hardware protection in both directions. It confirms a write with wp_n low leaves the lock and block-protect bits frozen but still lands quad enable. It then confirms that quad enable or full-quad releases the freeze; a design that tested the pin alone would refuse that write. It exercises the OTP lock: the data byte is ignored, the lock survives leaving and re-entering OTP mode, and a locked erase fails even with the region unprotected. A design that reused the plain lock bit would show 0 after exit or let the erase through. It also checks fail-flag ordering (a rejection both clears the other flag and sets its own), that a program with no write enable leaves an old flag untouched, the exact busy window length, a strobe dropped during busy, and that a warm reset keeps non-volatile bits while losing the volatile ones.

// File: rtl/sflash_status_pkg.sv
package sflash_status_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_SRWR       = 3'd1,
        ST_PGM_LAUNCH = 3'd2,
        ST_PGM_WAIT   = 3'd3,
        ST_ERS_LAUNCH = 3'd4,
        ST_ERS_WAIT   = 3'd5
    } fsr_state_e;

    // status byte bit positions (read path decodes these)
    localparam int SB_BUSY = 0;
    localparam int SB_WEL  = 1;
    localparam int SB_BP_LO = 2;
    localparam int SB_BP_HI = 5;
    localparam int SB_QE   = 6;
    localparam int SB_LOCK = 7;

    // info byte bit positions
    localparam int IB_A32   = 0;
    localparam int IB_OTP   = 1;
    localparam int IB_PFAIL = 2;
    localparam int IB_EFAIL = 3;

    typedef struct packed {
        logic       srp;
        logic       qe;
        logic [3:0] bp;
    } nv_bits_t;

endpackage

// File: rtl/sflash_status_fsm.sv
module sflash_status_fsm
    import sflash_status_pkg::*;
#(
    parameter int SRW_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wren,
    input  logic cmd_wrsr,
    input  logic cmd_en4b,
    input  logic cmd_ex4b,
    input  logic cmd_prog,
    input  logic cmd_erase,
    input  logic cmd_otp_enter,
    input  logic cmd_otp_exit,
    input  logic wel,
    input  logic op_blocked,
    input  logic seq_busy,
    input  logic seq_done,
    output logic fsm_busy,
    output logic acc_wren,
    output logic acc_wrsr,
    output logic acc_en4b,
    output logic acc_ex4b,
    output logic acc_otp_in,
    output logic acc_otp_out,
    output logic prog_reject,
    output logic erase_reject,
    output logic prog_accept,
    output logic erase_accept,
    output logic srwr_commit,
    output logic prog_end,
    output logic erase_end,
    output logic prog_go,
    output logic erase_go
);
    localparam int CW = (SRW_CYCLES < 2) ? 1 : $clog2(SRW_CYCLES);

    fsr_state_e state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic idle_ok;

    assign idle_ok = (state == ST_IDLE) && !seq_busy;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (!seq_busy && wel) begin
                    if (cmd_wrsr) begin
                        state_nxt = ST_SRWR;
                        cnt_nxt   = CW'(SRW_CYCLES - 1);
                    end else if (cmd_prog && !op_blocked) begin
                        state_nxt = ST_PGM_LAUNCH;
                    end else if (cmd_erase && !op_blocked) begin
                        state_nxt = ST_ERS_LAUNCH;
                    end
                end
            end
            ST_SRWR: begin
                if (cnt == '0) state_nxt = ST_IDLE;
                else           cnt_nxt   = cnt - 1'b1;
            end
            ST_PGM_LAUNCH: state_nxt = ST_PGM_WAIT;
            ST_PGM_WAIT:   if (seq_done) state_nxt = ST_IDLE;
            ST_ERS_LAUNCH: state_nxt = ST_ERS_WAIT;
            ST_ERS_WAIT:   if (seq_done) state_nxt = ST_IDLE;
            default:       state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fsm_busy     = 1'b1;
        acc_wren     = 1'b0;
        acc_wrsr     = 1'b0;
        acc_en4b     = 1'b0;
        acc_ex4b     = 1'b0;
        acc_otp_in   = 1'b0;
        acc_otp_out  = 1'b0;
        prog_reject  = 1'b0;
        erase_reject = 1'b0;
        prog_accept  = 1'b0;
        erase_accept = 1'b0;
        srwr_commit  = 1'b0;
        prog_end     = 1'b0;
        erase_end    = 1'b0;
        prog_go      = 1'b0;
        erase_go     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                fsm_busy = 1'b0;
                if (idle_ok) begin
                    if (cmd_wren)                 acc_wren     = 1'b1;
                    else if (cmd_wrsr && wel)     acc_wrsr     = 1'b1;
                    else if (cmd_prog && wel) begin
                        prog_accept = !op_blocked;
                        prog_reject = op_blocked;
                    end else if (cmd_erase && wel) begin
                        erase_accept = !op_blocked;
                        erase_reject = op_blocked;
                    end
                    else if (cmd_en4b)            acc_en4b     = 1'b1;
                    else if (cmd_ex4b)            acc_ex4b     = 1'b1;
                    else if (cmd_otp_enter)       acc_otp_in   = 1'b1;
                    else if (cmd_otp_exit)        acc_otp_out  = 1'b1;
                end
            end
            ST_SRWR:       srwr_commit = (cnt == '0);
            ST_PGM_LAUNCH: prog_go     = 1'b1;
            ST_PGM_WAIT:   prog_end    = seq_done;
            ST_ERS_LAUNCH: erase_go    = 1'b1;
            ST_ERS_WAIT:   erase_end   = seq_done;
            default:       fsm_busy    = 1'b1;
        endcase
    end

endmodule

// File: rtl/sflash_status_nv.sv
module sflash_status_nv
    import sflash_status_pkg::*;
(
    input  logic       clk,
    input  logic       nv_init_n,
    input  logic       acc_wrsr,
    input  logic       commit,
    input  logic [7:2] sr_wdata,
    input  logic       hw_protect,
    input  logic       otp_mode,
    output nv_bits_t   nv_q,
    output logic       otp_lock
);
    nv_bits_t pend_q;
    logic     pend_hwp;

    // capture data and protection verdict at acceptance
    always_ff @(posedge clk or negedge nv_init_n) begin
        if (!nv_init_n) begin
            pend_q   <= '0;
            pend_hwp <= 1'b0;
        end else if (acc_wrsr) begin
            pend_q   <= '{srp: sr_wdata[7], qe: sr_wdata[6], bp: sr_wdata[5:2]};
            pend_hwp <= hw_protect;
        end
    end

    // commit at the end of the write window
    always_ff @(posedge clk or negedge nv_init_n) begin
        if (!nv_init_n) begin
            nv_q     <= '0;
            otp_lock <= 1'b0;
        end else if (commit) begin
            if (otp_mode) begin
                otp_lock <= 1'b1;
            end else begin
                nv_q.qe <= pend_q.qe;
                if (!pend_hwp) begin
                    nv_q.srp <= pend_q.srp;
                    nv_q.bp  <= pend_q.bp;
                end
            end
        end
    end

endmodule

// File: rtl/sflash_status_vol.sv
module sflash_status_vol (
    input  logic clk,
    input  logic vol_rst_n,
    input  logic wel_set,
    input  logic wel_clr,
    input  logic set_a32,
    input  logic clr_a32,
    input  logic otp_in,
    input  logic otp_out,
    input  logic flag_clr,
    input  logic pfail_set,
    input  logic efail_set,
    output logic wel,
    output logic a32,
    output logic otp_mode,
    output logic pfail,
    output logic efail
);
    always_ff @(posedge clk or negedge vol_rst_n) begin
        if (!vol_rst_n) begin
            wel      <= 1'b0;
            a32      <= 1'b0;
            otp_mode <= 1'b0;
            pfail    <= 1'b0;
            efail    <= 1'b0;
        end else begin
            if (wel_set)      wel <= 1'b1;
            else if (wel_clr) wel <= 1'b0;

            if (set_a32)      a32 <= 1'b1;
            else if (clr_a32) a32 <= 1'b0;

            if (otp_in)       otp_mode <= 1'b1;
            else if (otp_out) otp_mode <= 1'b0;

            if (pfail_set)     pfail <= 1'b1;
            else if (flag_clr) pfail <= 1'b0;

            if (efail_set)     efail <= 1'b1;
            else if (flag_clr) efail <= 1'b0;
        end
    end

endmodule

// File: rtl/sflash_status_ctrl.sv
module sflash_status_ctrl
    import sflash_status_pkg::*;
#(
    parameter int SRW_CYCLES = 16
) (
    input  logic       clk,
    input  logic       nv_init_n,
    input  logic       rst_n,
    input  logic       cmd_wren,
    input  logic       cmd_wrsr,
    input  logic       cmd_en4b,
    input  logic       cmd_ex4b,
    input  logic       cmd_prog,
    input  logic       cmd_erase,
    input  logic       cmd_otp_enter,
    input  logic       cmd_otp_exit,
    input  logic       full_quad,
    input  logic       wp_n,
    input  logic [7:2] sr_wdata,
    input  logic       tgt_protected,
    input  logic       seq_busy,
    input  logic       seq_done,
    input  logic       seq_fail,
    output logic [7:0] status_reg,
    output logic [7:0] info_reg,
    output logic       wip,
    output logic       quad_read_ok,
    output logic       wp_hold_en,
    output logic       addr_32b,
    output logic       prog_go,
    output logic       erase_go
);
    logic vol_rst_n;
    logic fsm_busy, acc_wren, acc_wrsr, acc_en4b, acc_ex4b, acc_otp_in, acc_otp_out;
    logic prog_reject, erase_reject, prog_accept, erase_accept;
    logic srwr_commit, prog_end, erase_end;
    logic wel, a32, otp_mode, pfail, efail, otp_lock;
    logic hw_protect, op_blocked;
    nv_bits_t nv_q;

    assign vol_rst_n    = rst_n & nv_init_n;
    assign quad_read_ok = nv_q.qe | full_quad;
    assign wp_hold_en   = ~quad_read_ok;
    assign hw_protect   = nv_q.srp & wp_hold_en & ~wp_n;
    assign op_blocked   = otp_mode ? otp_lock : tgt_protected;

    sflash_status_fsm #(.SRW_CYCLES(SRW_CYCLES)) u_fsm (
        .clk           (clk),
        .rst_n         (vol_rst_n),
        .cmd_wren      (cmd_wren),
        .cmd_wrsr      (cmd_wrsr),
        .cmd_en4b      (cmd_en4b),
        .cmd_ex4b      (cmd_ex4b),
        .cmd_prog      (cmd_prog),
        .cmd_erase     (cmd_erase),
        .cmd_otp_enter (cmd_otp_enter),
        .cmd_otp_exit  (cmd_otp_exit),
        .wel           (wel),
        .op_blocked    (op_blocked),
        .seq_busy      (seq_busy),
        .seq_done      (seq_done),
        .fsm_busy      (fsm_busy),
        .acc_wren      (acc_wren),
        .acc_wrsr      (acc_wrsr),
        .acc_en4b      (acc_en4b),
        .acc_ex4b      (acc_ex4b),
        .acc_otp_in    (acc_otp_in),
        .acc_otp_out   (acc_otp_out),
        .prog_reject   (prog_reject),
        .erase_reject  (erase_reject),
        .prog_accept   (prog_accept),
        .erase_accept  (erase_accept),
        .srwr_commit   (srwr_commit),
        .prog_end      (prog_end),
        .erase_end     (erase_end),
        .prog_go       (prog_go),
        .erase_go      (erase_go)
    );

    sflash_status_nv u_nv (
        .clk        (clk),
        .nv_init_n  (nv_init_n),
        .acc_wrsr   (acc_wrsr),
        .commit     (srwr_commit),
        .sr_wdata   (sr_wdata),
        .hw_protect (hw_protect),
        .otp_mode   (otp_mode),
        .nv_q       (nv_q),
        .otp_lock   (otp_lock)
    );

    sflash_status_vol u_vol (
        .clk       (clk),
        .vol_rst_n (vol_rst_n),
        .wel_set   (acc_wren),
        .wel_clr   (srwr_commit | prog_end | erase_end | prog_reject | erase_reject),
        .set_a32   (acc_en4b),
        .clr_a32   (acc_ex4b),
        .otp_in    (acc_otp_in),
        .otp_out   (acc_otp_out),
        .flag_clr  (acc_wrsr | prog_accept | prog_reject | erase_accept | erase_reject),
        .pfail_set (prog_reject | (prog_end & seq_fail)),
        .efail_set (erase_reject | (erase_end & seq_fail)),
        .wel       (wel),
        .a32       (a32),
        .otp_mode  (otp_mode),
        .pfail     (pfail),
        .efail     (efail)
    );

    assign wip      = fsm_busy | seq_busy;
    assign addr_32b = a32;

    always_comb begin
        status_reg                  = '0;
        status_reg[SB_BUSY]         = wip;
        status_reg[SB_WEL]          = wel;
        status_reg[SB_BP_HI:SB_BP_LO] = nv_q.bp;
        status_reg[SB_QE]           = nv_q.qe;
        status_reg[SB_LOCK]         = otp_mode ? otp_lock : nv_q.srp;
        info_reg                    = '0;
        info_reg[IB_A32]            = a32;
        info_reg[IB_OTP]            = otp_mode;
        info_reg[IB_PFAIL]          = pfail;
        info_reg[IB_EFAIL]          = efail;
    end

endmodule

// File: rtl/sflash_status_chk.sv
module sflash_status_chk (
    input logic       clk,
    input logic       nv_init_n,
    input logic       rst_n,
    input logic       cmd_en4b,
    input logic       full_quad,
    input logic [7:0] status_reg,
    input logic [7:0] info_reg,
    input logic       wip,
    input logic       quad_read_ok,
    input logic       wp_hold_en,
    input logic       addr_32b,
    input logic       prog_go,
    input logic       erase_go,
    input logic       otp_lock
);
    AST_GO_WITH_WEL: assert property (@(posedge clk) disable iff (!nv_init_n || !rst_n)
        (prog_go || erase_go) |-> status_reg[1]); // R12

    AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (!nv_init_n || !rst_n)
        $onehot0({prog_go, erase_go})); // R12

    AST_GO_BUSY: assert property (@(posedge clk) disable iff (!nv_init_n || !rst_n)
        (prog_go || erase_go) |-> wip); // R1

    AST_WEL_CLEARED: assert property (@(posedge clk) disable iff (!nv_init_n || !rst_n)
        $fell(wip) |-> !status_reg[1]); // R3

    AST_NV_ONLY_BY_WRSR: assert property (@(posedge clk) disable iff (!nv_init_n || !rst_n)
        !$stable(status_reg[6:2]) |-> $past(wip)); // R4

    AST_FULL_QUAD: assert property (@(posedge clk) disable iff (!nv_init_n || !rst_n)
        full_quad |-> (quad_read_ok && !wp_hold_en)); // R5

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!nv_init_n)
        $past(otp_lock) |-> otp_lock); // R7

    AST_FLAGS_CLEAR_AT_GO: assert property (@(posedge clk) disable iff (!nv_init_n || !rst_n)
        (prog_go || erase_go) |-> (info_reg[3:2] == 2'b00)); // R10

    AST_BUSY_DROPS_CMD: assert property (@(posedge clk) disable iff (!nv_init_n || !rst_n)
        (wip && cmd_en4b) |=> $stable(addr_32b)); // R11

endmodule

bind sflash_status_ctrl sflash_status_chk u_chk (
    .clk          (clk),
    .nv_init_n    (nv_init_n),
    .rst_n        (rst_n),
    .cmd_en4b     (cmd_en4b),
    .full_quad    (full_quad),
    .status_reg   (status_reg),
    .info_reg     (info_reg),
    .wip          (wip),
    .quad_read_ok (quad_read_ok),
    .wp_hold_en   (wp_hold_en),
    .addr_32b     (addr_32b),
    .prog_go      (prog_go),
    .erase_go     (erase_go),
    .otp_lock     (otp_lock)
);

// File: tb/sim_sflash_status_ctrl.sv
`timescale 1ns/100ps
module sim_sflash_status_ctrl;
    localparam int SRW = 16;

    logic clk = 1'b0;
    logic nv_init_n = 1'b0, rst_n = 1'b0;
    logic cmd_wren = 0, cmd_wrsr = 0, cmd_en4b = 0, cmd_ex4b = 0;
    logic cmd_prog = 0, cmd_erase = 0, cmd_otp_enter = 0, cmd_otp_exit = 0;
    logic full_quad = 0, wp_n = 1, tgt_protected = 0;
    logic [7:2] sr_wdata = '0;
    logic seq_busy = 0, seq_done = 0, seq_fail = 0;
    logic [7:0] status_reg, info_reg;
    logic wip, quad_read_ok, wp_hold_en, addr_32b, prog_go, erase_go;

    logic cur_fail = 0;
    int   n_tests = 0, n_fail = 0;
    bit   finished = 0;

    always #2.5 clk = ~clk;

    sflash_status_ctrl #(.SRW_CYCLES(SRW)) u0 (.*);

    // command codes used by the vector table
    localparam logic [3:0] C_WREN = 4'd0, C_WRSR = 4'd1, C_EN4B = 4'd2, C_EX4B = 4'd3,
                           C_PROG = 4'd4, C_ERASE = 4'd5, C_OTPIN = 4'd6, C_OTPOUT = 4'd7;

    // {cmd, data byte, wp_n, tgt_protected, seq_fail, expected status, expected info}
    localparam int NV = 39;
    localparam logic [30:0] VEC [NV] = '{
        {C_WREN,  8'h00, 3'b100, 8'h02, 8'h00}, // R2
        {C_WRSR,  8'h3C, 3'b100, 8'h3C, 8'h00}, // R4 R3
        {C_WREN,  8'h00, 3'b100, 8'h3E, 8'h00},
        {C_PROG,  8'h00, 3'b110, 8'h3C, 8'h04}, // R8 R10
        {C_WREN,  8'h00, 3'b100, 8'h3E, 8'h04},
        {C_ERASE, 8'h00, 3'b110, 8'h3C, 8'h08}, // R10
        {C_WREN,  8'h00, 3'b100, 8'h3E, 8'h08},
        {C_PROG,  8'h00, 3'b101, 8'h3C, 8'h04}, // R10
        {C_PROG,  8'h00, 3'b100, 8'h3C, 8'h04}, // R2
        {C_WREN,  8'h00, 3'b100, 8'h3E, 8'h04},
        {C_PROG,  8'h00, 3'b100, 8'h3C, 8'h00}, // R10
        {C_WREN,  8'h00, 3'b100, 8'h3E, 8'h00},
        {C_ERASE, 8'h00, 3'b101, 8'h3C, 8'h08}, // R10
        {C_EN4B,  8'h00, 3'b100, 8'h3C, 8'h09}, // R9
        {C_EX4B,  8'h00, 3'b100, 8'h3C, 8'h08}, // R9
        {C_EN4B,  8'h00, 3'b100, 8'h3C, 8'h09},
        {C_WREN,  8'h00, 3'b100, 8'h3E, 8'h09},
        {C_WRSR,  8'h80, 3'b100, 8'h80, 8'h01}, // R4
        {C_WREN,  8'h00, 3'b000, 8'h82, 8'h01},
        {C_WRSR,  8'h3C, 3'b000, 8'h80, 8'h01}, // R6
        {C_WREN,  8'h00, 3'b000, 8'h82, 8'h01},
        {C_WRSR,  8'h40, 3'b000, 8'hC0, 8'h01}, // R6
        {C_WREN,  8'h00, 3'b000, 8'hC2, 8'h01},
        {C_WRSR,  8'h3C, 3'b000, 8'h3C, 8'h01}, // R5
        {C_WREN,  8'h00, 3'b100, 8'h3E, 8'h01},
        {C_WRSR,  8'h00, 3'b100, 8'h00, 8'h01},
        {C_OTPIN, 8'h00, 3'b100, 8'h00, 8'h03}, // R7
        {C_WREN,  8'h00, 3'b100, 8'h02, 8'h03},
        {C_PROG,  8'h00, 3'b110, 8'h00, 8'h03}, // R8
        {C_WREN,  8'h00, 3'b100, 8'h02, 8'h03},
        {C_WRSR,  8'hFF, 3'b100, 8'h80, 8'h03}, // R7
        {C_WREN,  8'h00, 3'b100, 8'h82, 8'h03},
        {C_ERASE, 8'h00, 3'b100, 8'h80, 8'h0B}, // R8
        {C_OTPOUT,8'h00, 3'b100, 8'h00, 8'h09}, // R7
        {C_OTPIN, 8'h00, 3'b100, 8'h80, 8'h0B}, // R7
        {C_WREN,  8'h00, 3'b100, 8'h82, 8'h0B},
        {C_WRSR,  8'h00, 3'b100, 8'h80, 8'h03}, // R7 R10
        {C_OTPOUT,8'h00, 3'b100, 8'h00, 8'h01},
        {C_EX4B,  8'h00, 3'b100, 8'h00, 8'h00}
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 200 && wip; k++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic do_cmd(input logic [3:0] c, input logic [7:0] d);
        @(negedge clk);
        sr_wdata = d[7:2];
        case (c)
            C_WREN:   cmd_wren = 1;
            C_WRSR:   cmd_wrsr = 1;
            C_EN4B:   cmd_en4b = 1;
            C_EX4B:   cmd_ex4b = 1;
            C_PROG:   cmd_prog = 1;
            C_ERASE:  cmd_erase = 1;
            C_OTPIN:  cmd_otp_enter = 1;
            C_OTPOUT: cmd_otp_exit = 1;
            default:  ;
        endcase
        @(negedge clk);
        {cmd_wren, cmd_wrsr, cmd_en4b, cmd_ex4b, cmd_prog, cmd_erase,
         cmd_otp_enter, cmd_otp_exit} = '0;
        #1;
        wait_idle();
    endtask

    // sequencer model
    initial begin
        forever begin
            @(negedge clk);
            if (prog_go || erase_go) begin
                seq_busy = 1;
                repeat (3) @(negedge clk);
                seq_done = 1;
                seq_fail = cur_fail;
                @(negedge clk);
                seq_done = 0;
                seq_fail = 0;
                seq_busy = 0;
            end
        end
    end

    // watchdog
    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        nv_init_n = 1;
        rst_n = 1;
        @(negedge clk); #1;
        // reset state
        check("R1 reset status", status_reg, 8'h00);
        check("R9 reset info", info_reg, 8'h00);
        check("R5 reset gating", {6'b0, quad_read_ok, wp_hold_en}, 8'h01);
        check("R12 reset go", {6'b0, prog_go, erase_go}, 8'h00);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            wp_n          = VEC[i][18];
            tgt_protected = VEC[i][17];
            cur_fail      = VEC[i][16];
            do_cmd(VEC[i][30:27], VEC[i][26:19]);
            check($sformatf("vec%0d status R2 R3 R4 R6 R7", i), status_reg, VEC[i][15:8]);
            check($sformatf("vec%0d info R7 R8 R9 R10", i), info_reg, VEC[i][7:0]);
        end
        wp_n = 1; tgt_protected = 0; cur_fail = 0;

        // quad gating
        check("R5 qe0 gating", {6'b0, quad_read_ok, wp_hold_en}, 8'h01);
        @(negedge clk); full_quad = 1; #1;
        check("R5 full quad gating", {6'b0, quad_read_ok, wp_hold_en}, 8'h02);
        @(negedge clk); full_quad = 0;

        // busy window length and a dropped strobe
        do_cmd(C_WREN, 8'h00);
        @(negedge clk);
        sr_wdata = 6'h00;
        cmd_wrsr = 1;
        @(negedge clk);
        cmd_wrsr = 0;
        cmd_en4b = 1;
        #1;
        cnt = 0;
        check("R1 busy bit in window", {7'b0, status_reg[0]}, 8'h01);
        for (int k = 0; k < 100 && wip; k++) begin
            cnt++;
            @(negedge clk);
            cmd_en4b = 0;
            #1;
        end
        check("R1 busy window length", 8'(cnt), 8'(SRW));
        check("R11 strobe during busy ignored", info_reg, 8'h00);

        // warm reset keeps non-volatile bits
        do_cmd(C_WREN, 8'h00);
        do_cmd(C_WRSR, 8'h44);
        do_cmd(C_EN4B, 8'h00);
        tgt_protected = 1;
        do_cmd(C_WREN, 8'h00);
        do_cmd(C_PROG, 8'h00);
        tgt_protected = 0;
        check("R10 pre-reset info", info_reg, 8'h05);
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1; #1;
        check("R4 status after warm reset", status_reg, 8'h44);
        check("R9 R10 info after warm reset", info_reg, 8'h00);
        check("R5 qe1 gating", {6'b0, quad_read_ok, wp_hold_en}, 8'h02);

        // factory init clears all
        @(negedge clk); nv_init_n = 0;
        @(negedge clk); @(negedge clk); nv_init_n = 1; #1;
        check("R4 status after init", status_reg, 8'h00);

        // full quad disables hardware protection
        do_cmd(C_WREN, 8'h00);
        do_cmd(C_WRSR, 8'h80);
        full_quad = 1; wp_n = 0;
        do_cmd(C_WREN, 8'h00);
        do_cmd(C_WRSR, 8'h3C);
        check("R5 full quad frees protection", status_reg, 8'h3C);
        full_quad = 0; wp_n = 1;

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule